// File: doc/BRIEF.md
# Unconditional Jump Next-PC Unit

This unit works out where the program counter goes next for the unconditional transfer forms of an 8/16-bit core with a 24-bit address space. The decoder supplies a jump-kind code, the instruction length in bytes, the address field taken from the instruction, a signed 8-bit displacement, the accumulator and the 16-bit data pointer. From these the unit builds the target address combinationally. It also returns the number of execution states the transfer costs. That cost depends on whether the target lies in on-chip memory (below `INT_LIMIT`) or outside it, and on whether an on-chip target has an odd address.

A single strobe commits the computed target into the PC register. If the strobe arrives with a code that names no jump kind, the PC keeps its value and a flag is raised for the following cycle. Fetch, decode, memory access and conditional branches are handled elsewhere.

Top module: `jump_pc_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it goes high, `pc_q` equals `RESET_PC` (default 0) and `illegal` is 0.
- R2: Kind code 1 (absolute) produces a target whose bits 10:0 come from `addr_fld[10:0]`. Bits 23:11 of the target come from `pc_q + 2`.
- R3: Kind code 2 (extended) produces a target equal to all 24 bits of `addr_fld`. Kind codes 2 and 3 use `isize` as their advance; the advance matters only for code 3.
- R4: Kind code 3 (long) produces a target whose bits 15:0 come from `addr_fld[15:0]`. Bits 23:16 of the target come from `pc_q + isize`.
- R5: Kind code 4 (short) produces a target of `pc_q + 2` plus `rel` sign-extended to 24 bits. The sum wraps modulo 2^24.
- R6: Kind code 5 (indirect) produces a target with bits 23:16 set to FFh. Bits 15:0 are `acc + dptr` taken modulo 2^16.
- R7: Kind code 0 (no-operation) produces a target of `pc_q + 1`, wrapping modulo 2^24.
- R8: `pc_q` loads `next_pc` on a rising clock edge only when `step` is high. Otherwise it holds its value.
- R9: The base state cost is 1 for code 0, 3 for code 1, 5 for code 2, 4 for code 3, 4 for code 4 and 5 for code 5. Code 0 always costs exactly 1.
- R10: For codes 1 to 5 with an on-chip target (target < `INT_LIMIT`, default 0x010000), one state is added when `int_exec` is 1 and the target is odd. Otherwise nothing is added.
- R11: For codes 1 to 5 with an external target (target >= `INT_LIMIT`), 2 states are added for code 1 and 3 states for codes 2 to 5.
- R12: Codes 6 and 7 are illegal. For these, `next_pc` equals `pc_q` and `states` is 0. A strobe with an illegal code leaves `pc_q` unchanged and sets `illegal` high for exactly the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | Commit strobe for the PC register |
| kind | input | 3 | Jump-kind code (0 to 5 legal) |
| isize | input | 3 | Instruction length in bytes |
| addr_fld | input | 24 | Address field from the instruction |
| rel | input | 8 | Signed displacement |
| acc | input | 8 | Accumulator value |
| dptr | input | 16 | Data pointer value |
| int_exec | input | 1 | High when executing from on-chip memory |
| pc_q | output | 24 | Program counter register |
| next_pc | output | 24 | Computed target address |
| states | output | 4 | Execution state cost of the transfer |
| illegal | output | 1 | One-cycle flag after a strobe with an illegal code |

## Verification
The in-RTL assertions check on every cycle that the PC holds without a strobe, that indirect transfers land with an all-ones top byte, and that absolute transfers keep bits 23:11 of the advanced PC. They also check that no-operation advances by one and that illegal codes hold the PC and raise a single-cycle flag. Some behaviours appear only in the bench's directed and random scenarios against its behavioural model. These are the exact short-displacement arithmetic across the 2^24 wrap, the 16-bit truncation of the accumulator plus data pointer sum, and the state cost for every mix of target location, parity and `int_exec`.

// File: rtl/jump_pc_unit.sv
module jump_pc_unit #(
  parameter logic [23:0] RESET_PC  = 24'h000000,
  parameter logic [23:0] INT_LIMIT = 24'h010000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step,
  input  logic [2:0]  kind,
  input  logic [2:0]  isize,
  input  logic [23:0] addr_fld,
  input  logic [7:0]  rel,
  input  logic [7:0]  acc,
  input  logic [15:0] dptr,
  input  logic        int_exec,
  output logic [23:0] pc_q,
  output logic [23:0] next_pc,
  output logic [3:0]  states,
  output logic        illegal
);

  typedef enum logic [2:0] {
    K_NOP = 3'd0, K_ABS = 3'd1, K_EXT = 3'd2,
    K_LONG = 3'd3, K_SHORT = 3'd4, K_IND = 3'd5
  } kind_e;

  logic [23:0] adv1, adv2, advn, rel_ext;
  logic [15:0] ind_lo;
  logic [3:0]  base, extra;
  logic        legal, has_tgt, ext_tgt;

  assign adv1    = pc_q + 24'd1;
  assign adv2    = pc_q + 24'd2;
  assign advn    = pc_q + {21'd0, isize};
  assign rel_ext = {{16{rel[7]}}, rel};
  assign ind_lo  = {8'd0, acc} + dptr;

  always_comb begin
    legal   = 1'b1;
    has_tgt = 1'b1;
    base    = 4'd0;
    extra   = 4'd3;
    next_pc = pc_q;
    case (kind)
      K_NOP:   begin next_pc = adv1; base = 4'd1; has_tgt = 1'b0; end
      K_ABS:   begin next_pc = {adv2[23:11], addr_fld[10:0]}; base = 4'd3; extra = 4'd2; end
      K_EXT:   begin next_pc = addr_fld; base = 4'd5; end
      K_LONG:  begin next_pc = {advn[23:16], addr_fld[15:0]}; base = 4'd4; end
      K_SHORT: begin next_pc = adv2 + rel_ext; base = 4'd4; end
      K_IND:   begin next_pc = {8'hFF, ind_lo}; base = 4'd5; end
      default: begin legal = 1'b0; has_tgt = 1'b0; end
    endcase
  end

  assign ext_tgt = next_pc >= INT_LIMIT;
  assign states  = !has_tgt ? base :
                   ext_tgt  ? base + extra :
                   (int_exec && next_pc[0]) ? base + 4'd1 : base;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q    <= RESET_PC;
      illegal <= 1'b0;
    end else begin
      if (step && legal) pc_q <= next_pc;
      illegal <= step && !legal;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pc_q)); // R8
  AST_NOP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (step && kind == 3'd0) |=> pc_q == $past(adv1)); // R7
  AST_ABS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (step && kind == 3'd1) |=> pc_q[23:11] == $past(adv2[23:11])); // R2
  AST_EXT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (step && kind == 3'd2) |=> pc_q == $past(addr_fld)); // R3
  AST_IND_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && kind == 3'd5) |=> pc_q[23:16] == 8'hFF); // R6
  AST_ILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (step && kind[2:1] == 2'b11) |=> ($stable(pc_q) && illegal)); // R12
  AST_ILL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> $past(step)); // R12
  AST_ILL_NOCOST: assert property (@(posedge clk) disable iff (!rst_n)
    (kind[2:1] == 2'b11) |-> (states == 4'd0 && next_pc == pc_q)); // R12
  AST_NOP_COST: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == 3'd0) |-> states == 4'd1); // R9

endmodule

// File: tb/jump_pc_unit_test.sv
module jump_pc_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step = 1'b0;
  logic [2:0]  kind = '0, isize = '0;
  logic [23:0] addr_fld = '0;
  logic [7:0]  rel = '0, acc = '0;
  logic [15:0] dptr = '0;
  logic        int_exec = 1'b0;
  logic [23:0] pc_q, next_pc;
  logic [3:0]  states;
  logic        illegal;

  int checks = 0, errors = 0;
  int mpc = 0;
  bit mill = 0;
  bit done = 0;

  always #4 clk = ~clk;

  jump_pc_unit uut (
    .clk(clk), .rst_n(rst_n), .step(step), .kind(kind), .isize(isize),
    .addr_fld(addr_fld), .rel(rel), .acc(acc), .dptr(dptr), .int_exec(int_exec),
    .pc_q(pc_q), .next_pc(next_pc), .states(states), .illegal(illegal)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void model(input int pc, input int k, input int sz, input int im,
                                input int r, input int a, input int dp, input bit ie,
                                output int t, output int st, output bit lg, output string tg);
    int base, xtra;
    bit has;
    lg = 1; has = 1; xtra = 3; base = 0; t = pc;
    case (k)
      0: begin t = pc + 1; base = 1; has = 0; tg = "R7"; end
      1: begin t = (((pc + 2) & 'hFFFFFF) & 'hFFF800) | (im & 'h7FF); base = 3; xtra = 2; tg = "R2"; end
      2: begin t = im; base = 5; tg = "R3"; end
      3: begin t = (((pc + sz) & 'hFFFFFF) & 'hFF0000) | (im & 'hFFFF); base = 4; tg = "R4"; end
      4: begin t = pc + 2 + ((r >= 128) ? r - 256 : r); base = 4; tg = "R5"; end
      5: begin t = 'hFF0000 | ((a + dp) & 'hFFFF); base = 5; tg = "R6"; end
      default: begin lg = 0; has = 0; tg = "R12"; end
    endcase
    t = t & 'hFFFFFF;
    if (!has) st = base;
    else if (t >= 'h010000) st = base + xtra;
    else if (ie && (t % 2 == 1)) st = base + 1;
    else st = base;
  endfunction

  task automatic regs_check();
    @(negedge clk);
    chk("R8 pc_q", pc_q, mpc);
    chk("R12 illegal", illegal, mill);
  endtask

  task automatic cyc(input bit st, input int k, input int sz, input int im, input int r,
                     input int a, input int dp, input bit ie);
    int t, c;
    bit lg;
    string tg;
    regs_check();
    step = st; kind = k[2:0]; isize = sz[2:0]; addr_fld = im[23:0];
    rel = r[7:0]; acc = a[7:0]; dptr = dp[15:0]; int_exec = ie;
    #1;
    model(mpc, k & 7, sz & 7, im & 'hFFFFFF, r & 'hFF, a & 'hFF, dp & 'hFFFF, ie, t, c, lg, tg);
    chk({tg, " next_pc"}, next_pc, t);
    if (!lg) chk("R12 states", states, c);
    else if (k == 0) chk("R9 states", states, c);
    else if (t >= 'h010000) chk("R11 states", states, c);
    else if (ie && (t % 2 == 1)) chk("R10 states", states, c);
    else chk("R9 states", states, c);
    if (st && lg) mpc = t;
    mill = st && !lg;
  endtask

  initial begin
    #1600000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog R8 actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset pc_q", pc_q, 0);
    chk("R1 reset illegal", illegal, 0);
    rst_n = 1'b1;
    cyc(1, 2, 5, 'h123456, 0, 0, 0, 1);      // R3 external load, R11 cost
    cyc(1, 1, 2, 'h0007FF, 0, 0, 0, 1);      // R2 keeps upper bits
    cyc(1, 3, 3, 'h000101, 0, 0, 0, 1);      // R4
    cyc(1, 2, 4, 'h000100, 0, 0, 0, 1);      // R3 internal even
    cyc(1, 4, 2, 0, 'h81, 0, 0, 1);          // R5 negative displacement
    cyc(1, 4, 2, 0, 'h7F, 0, 0, 0);          // R5 positive displacement
    cyc(1, 2, 4, 'h000000, 0, 0, 0, 1);
    cyc(1, 4, 2, 0, 'hFB, 0, 0, 1);          // R5 wrap below zero
    cyc(1, 2, 4, 'hFFFFFF, 0, 0, 0, 0);
    cyc(1, 0, 1, 0, 0, 0, 0, 1);             // R7 wrap to zero
    cyc(1, 3, 3, 'h000011, 0, 0, 0, 1);      // R10 odd internal with int_exec
    cyc(0, 3, 3, 'h000011, 0, 0, 0, 0);      // R10 odd internal without int_exec
    cyc(0, 1, 2, 'h000555, 0, 0, 0, 1);      // R8 no strobe
    cyc(1, 5, 1, 0, 0, 'hFF, 'hFFFF, 1);     // R6 16-bit truncation
    cyc(1, 6, 1, 'h000033, 0, 0, 0, 1);      // R12 illegal
    cyc(1, 7, 1, 0, 0, 0, 0, 1);             // R12 illegal back-to-back
    cyc(1, 0, 1, 0, 0, 0, 0, 1);             // R12 flag drops
    cyc(0, 0, 1, 0, 0, 0, 0, 1);
    for (int i = 0; i < 4000; i++)
      cyc($urandom_range(0, 3) != 0, $urandom_range(0, 7), $urandom_range(0, 7),
          ($urandom_range(0, 1) != 0) ? ($urandom & 'h00FFFF) : ($urandom & 'hFFFFFF),
          $urandom & 'hFF, $urandom & 'hFF, $urandom & 'hFFFF, $urandom_range(0, 1) != 0);
    regs_check();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule